// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block paces one successive-approximation conversion at a time for a single converter shared by a set of analog channels. From the system clock it derives a slower converter clock whose period is set by a prescale field. Each conversion runs three timed phases in that converter clock. The first is a warm-up delay counted in groups of eight clocks. The second is a sample-and-hold window. The third is a fixed run of bit cycles, one per result bit. At the end of the sample-and-hold window the block captures the converter's digital output. When the bit cycles finish, the captured value is published in a result register and a ready flag is raised.

A conversion can start in two ways: software sets a start bit, or a rising edge arrives on one of several external trigger inputs, picked by a select field and gated by an enable bit. The converter input mux is steered to the lowest-numbered enabled channel. Software accesses the block through a small word-addressed register port. The port holds a command register, a mode register, a channel mask, a status word and the result. Reads take effect in the same cycle as the address. A software-reset command returns the whole block to its power-up state.

Top module: `adc_seq`

## Requirements
- R1: During a conversion, `adc_clk` has a period of (P+1)*2 system clocks, where P is the prescale field (mode bits 15:8). It is high for the first P+1 cycles of each period, counted from the edge that starts the conversion, and it is low whenever the block is idle.
- R2: With startup field S (mode bits 20:16) and hold field H (mode bits 27:24), `busy` is high and `data_ready` is low for exactly ((S+1)*8 + (H+1) + DATA_W) converter periods after the start edge. On the edge that ends that interval, `data_ready` rises and `busy` falls.
- R3: The mode register is at address 1. Bit 0 is the trigger enable, bits 2:1 are the trigger select, and the P, S and H fields sit at the positions given above. Every other bit reads 0. The channel mask is at address 2, and address 0 always reads 0.
- R4: The result register (address 4) holds in bits DATA_W-1:0 the value on `adc_sample` at the clock edge that closes the sample-and-hold window. Later changes of `adc_sample` during the bit cycles have no effect.
- R5: A conversion uses the lowest-numbered set bit of the channel mask. It drives that index on `adc_chan` for the whole conversion and stores it in result bits 18:16. A start request while the mask is zero is ignored.
- R6: Writing address 0 with bit 1 set and bit 0 clear starts a conversion on the edge that samples the write.
- R7: When the trigger enable is set, a rising level on `trig_in[sel]` starts a conversion on the third clock edge after the input rises, because of two synchronizer stages. Edges on other inputs, and any edge while the enable is clear, start nothing.
- R8: Trigger edges and software starts that arrive while `busy` is high are ignored. They neither restart nor lengthen the running conversion, and they do not queue a further one.
- R9: Status (address 3) holds ready in bit 0, overrun in bit 1 and busy in bit 2. Reading the result clears ready. A result that completes while ready is still set raises overrun. Reading the status clears overrun.
- R10: Writing address 0 with bit 0 set aborts any conversion and clears mode, mask, status and result to 0 on that edge. A start bit in the same write is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (drives read side effects) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid in the same cycle as the address |
| trig_in | input | NUM_TRIG | External trigger inputs, asynchronous |
| adc_sample | input | DATA_W | Digital output of the converter model |
| adc_clk | output | 1 | Divided converter clock |
| adc_chan | output | CH_W | Channel index for the analog input mux |
| busy | output | 1 | A conversion is in progress |
| data_ready | output | 1 | An unread result is available |

## Verification
Every result follows a closed-form cycle count. A software start takes effect on the edge that samples the write. A trigger takes effect three edges after the input rises. Capture happens ((S+1)*8+H+1)*(P+1)*2 edges after the start, and ready rises DATA_W*(P+1)*2 edges after capture. Register reads return data combinationally, and their side effects land on the following edge. The bench counts falling edges from the start edge and samples each output at the exact count the formula gives. This applies across a sweep of every small prescale, startup and hold setting, so an off-by-one in any phase or in the divider changes the observed cycle. The sample input is switched right after the capture edge, so a capture one edge late shows up in the result.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_WARM = 2'd1,
    SEQ_HOLD = 2'd2,
    SEQ_CONV = 2'd3
  } seq_state_e;

  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] RA_CTRL = 3'd0;
  localparam logic [REG_AW-1:0] RA_MODE = 3'd1;
  localparam logic [REG_AW-1:0] RA_CHEN = 3'd2;
  localparam logic [REG_AW-1:0] RA_STAT = 3'd3;
  localparam logic [REG_AW-1:0] RA_DATA = 3'd4;

  localparam int CTL_RST_BIT   = 0;
  localparam int CTL_START_BIT = 1;

  localparam int MODE_TEN_BIT  = 0;
  localparam int MODE_TSEL_LSB = 1;
  localparam int MODE_PRE_LSB  = 8;
  localparam int MODE_STUP_LSB = 16;
  localparam int MODE_SHT_LSB  = 24;

  localparam int STAT_RDY_BIT  = 0;
  localparam int STAT_OVR_BIT  = 1;
  localparam int STAT_BUSY_BIT = 2;

  localparam int DATA_CH_LSB   = 16;

endpackage

// File: rtl/adcseq_clkdiv.sv
module adcseq_clkdiv #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PRE_W-1:0] prescal,
  output logic             tick,
  output logic             adc_clk
);

  localparam int CW = PRE_W + 2;

  logic [CW-1:0] half_len;
  logic [CW-1:0] period;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          wrap;

  // half period is prescal+1, full period twice that
  assign half_len = CW'(prescal) + CW'(1);
  assign period   = {half_len[CW-2:0], 1'b0};
  assign wrap     = (cnt_q >= (period - CW'(1)));

  always_comb begin
    cnt_d = cnt_q;
    if (!run || wrap) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign tick    = run && wrap;
  assign adc_clk = run && (cnt_q < half_len);

endmodule

// File: rtl/adcseq_trig.sv
module adcseq_trig #(
  parameter int NUM_TRIG = 4,
  parameter int SEL_W    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_TRIG-1:0] trig_in,
  input  logic [SEL_W-1:0]    sel,
  input  logic                en,
  output logic                fire
);

  logic [NUM_TRIG-1:0] meta_q;
  logic [NUM_TRIG-1:0] sync_q;
  logic [NUM_TRIG-1:0] last_q;
  logic [NUM_TRIG-1:0] rise;

  // two synchronizer stages plus one history stage per input
  for (genvar g = 0; g < NUM_TRIG; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[g] <= 1'b0;
        sync_q[g] <= 1'b0;
        last_q[g] <= 1'b0;
      end else begin
        meta_q[g] <= trig_in[g];
        sync_q[g] <= meta_q[g];
        last_q[g] <= sync_q[g];
      end
    end
    assign rise[g] = sync_q[g] && !last_q[g];
  end

  assign fire = en && rise[sel];

endmodule

// File: rtl/adcseq_chsel.sv
module adcseq_chsel #(
  parameter int NUM_CH = 8,
  parameter int CH_W   = 3
) (
  input  logic [NUM_CH-1:0] mask,
  output logic              any,
  output logic [CH_W-1:0]   idx
);

  // scan downward so the lowest set bit is the last one written
  always_comb begin
    idx = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (mask[i]) begin
        idx = CH_W'(i);
      end
    end
  end

  assign any = |mask;

endmodule

// File: rtl/adcseq_fsm.sv
module adcseq_fsm
  import adcseq_pkg::*;
#(
  parameter int STUP_W   = 5,
  parameter int SHT_W    = 4,
  parameter int CONV_CYC = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              start,
  input  logic              tick,
  input  logic [STUP_W-1:0] startup,
  input  logic [SHT_W-1:0]  shtim,
  output logic              busy,
  output logic              hold_end,
  output logic              done
);

  localparam int WW  = STUP_W + 4;
  localparam int HW  = SHT_W + 1;
  localparam int CVW = $clog2(CONV_CYC + 1);
  localparam int CW  = (WW > HW) ? ((WW > CVW) ? WW : CVW)
                                 : ((HW > CVW) ? HW : CVW);

  seq_state_e    state_q;
  seq_state_e    state_d;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic [CW-1:0] limit;
  logic [CW-1:0] warm_len;
  logic [CW-1:0] hold_len;
  logic [STUP_W:0] stup_p1;
  logic [SHT_W:0]  sht_p1;
  logic          last;

  assign stup_p1  = {1'b0, startup} + 1'b1;
  assign sht_p1   = {1'b0, shtim} + 1'b1;
  assign warm_len = CW'({stup_p1, 3'b000});
  assign hold_len = CW'(sht_p1);

  always_comb begin
    unique case (state_q)
      SEQ_WARM: limit = warm_len;
      SEQ_HOLD: limit = hold_len;
      SEQ_CONV: limit = CW'(CONV_CYC);
      default:  limit = '0;
    endcase
  end

  assign last = (state_q != SEQ_IDLE) && tick && (cnt_q >= (limit - CW'(1)));

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (clr) begin
      state_d = SEQ_IDLE;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (start) begin
            state_d = SEQ_WARM;
            cnt_d   = '0;
          end
        end
        default: begin
          if (last) begin
            cnt_d = '0;
            unique case (state_q)
              SEQ_WARM: state_d = SEQ_HOLD;
              SEQ_HOLD: state_d = SEQ_CONV;
              default:  state_d = SEQ_IDLE;
            endcase
          end else if (tick) begin
            cnt_d = cnt_q + CW'(1);
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign busy     = (state_q != SEQ_IDLE);
  assign hold_end = (state_q == SEQ_HOLD) && last && !clr;
  assign done     = (state_q == SEQ_CONV) && last && !clr;

endmodule

// File: rtl/adc_seq.sv
module adc_seq
  import adcseq_pkg::*;
#(
  parameter int DATA_W   = 10,
  parameter int NUM_CH   = 8,
  parameter int NUM_TRIG = 4,
  parameter int PRE_W    = 8,
  parameter int STUP_W   = 5,
  parameter int SHT_W    = 4,
  parameter int REG_DW   = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          reg_wr,
  input  logic                          reg_rd,
  input  logic [2:0]                    reg_addr,
  input  logic [REG_DW-1:0]             reg_wdata,
  output logic [REG_DW-1:0]             reg_rdata,
  input  logic [NUM_TRIG-1:0]           trig_in,
  input  logic [DATA_W-1:0]             adc_sample,
  output logic                          adc_clk,
  output logic [((NUM_CH > 1) ? $clog2(NUM_CH) : 1)-1:0] adc_chan,
  output logic                          busy,
  output logic                          data_ready
);

  localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int TSEL_W   = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1;
  localparam int CONV_CYC = DATA_W;

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rsync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= '0;
    end else begin
      rsync_q <= {rsync_q[0], 1'b1};
    end
  end

  assign rst_i_n = rsync_q[1];

  // register state
  logic              ten_q,   ten_d;
  logic [TSEL_W-1:0] tsel_q,  tsel_d;
  logic [PRE_W-1:0]  pre_q,   pre_d;
  logic [STUP_W-1:0] stup_q,  stup_d;
  logic [SHT_W-1:0]  sht_q,   sht_d;
  logic [NUM_CH-1:0] chen_q,  chen_d;
  logic              drdy_q,  drdy_d;
  logic              ovr_q,   ovr_d;
  logic [DATA_W-1:0] res_q,   res_d;
  logic [CH_W-1:0]   rch_q,   rch_d;
  logic [CH_W-1:0]   chan_q,  chan_d;
  logic [DATA_W-1:0] samp_q,  samp_d;

  // decode
  logic wr_ctrl, wr_mode, wr_chen;
  logic rd_data, rd_stat;
  logic soft_rst, sw_start, start_req;
  logic trig_fire, ch_any, tick;
  logic seq_busy, hold_end, seq_done;
  logic [CH_W-1:0] ch_idx;
  logic wdata_unused;

  assign wr_ctrl  = reg_wr && (reg_addr == RA_CTRL);
  assign wr_mode  = reg_wr && (reg_addr == RA_MODE);
  assign wr_chen  = reg_wr && (reg_addr == RA_CHEN);
  assign rd_data  = reg_rd && (reg_addr == RA_DATA);
  assign rd_stat  = reg_rd && (reg_addr == RA_STAT);
  assign soft_rst = wr_ctrl && reg_wdata[CTL_RST_BIT];
  assign sw_start = wr_ctrl && reg_wdata[CTL_START_BIT];

  assign start_req = (sw_start || trig_fire) && ch_any && !seq_busy && !soft_rst;

  assign wdata_unused = ^reg_wdata;

  adcseq_clkdiv #(
    .PRE_W (PRE_W)
  ) u_div (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .run     (seq_busy),
    .prescal (pre_q),
    .tick    (tick),
    .adc_clk (adc_clk)
  );

  adcseq_trig #(
    .NUM_TRIG (NUM_TRIG),
    .SEL_W    (TSEL_W)
  ) u_trig (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .trig_in (trig_in),
    .sel     (tsel_q),
    .en      (ten_q),
    .fire    (trig_fire)
  );

  adcseq_chsel #(
    .NUM_CH (NUM_CH),
    .CH_W   (CH_W)
  ) u_chsel (
    .mask (chen_q),
    .any  (ch_any),
    .idx  (ch_idx)
  );

  adcseq_fsm #(
    .STUP_W   (STUP_W),
    .SHT_W    (SHT_W),
    .CONV_CYC (CONV_CYC)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .clr      (soft_rst),
    .start    (start_req),
    .tick     (tick),
    .startup  (stup_q),
    .shtim    (sht_q),
    .busy     (seq_busy),
    .hold_end (hold_end),
    .done     (seq_done)
  );

  // next-state for the register file
  always_comb begin
    ten_d  = ten_q;
    tsel_d = tsel_q;
    pre_d  = pre_q;
    stup_d = stup_q;
    sht_d  = sht_q;
    chen_d = chen_q;
    drdy_d = drdy_q;
    ovr_d  = ovr_q;
    res_d  = res_q;
    rch_d  = rch_q;
    chan_d = chan_q;
    samp_d = samp_q;
    if (soft_rst) begin
      ten_d  = 1'b0;
      tsel_d = '0;
      pre_d  = '0;
      stup_d = '0;
      sht_d  = '0;
      chen_d = '0;
      drdy_d = 1'b0;
      ovr_d  = 1'b0;
      res_d  = '0;
      rch_d  = '0;
      chan_d = '0;
      samp_d = '0;
    end else begin
      if (wr_mode) begin
        ten_d  = reg_wdata[MODE_TEN_BIT];
        tsel_d = reg_wdata[MODE_TSEL_LSB +: TSEL_W];
        pre_d  = reg_wdata[MODE_PRE_LSB +: PRE_W];
        stup_d = reg_wdata[MODE_STUP_LSB +: STUP_W];
        sht_d  = reg_wdata[MODE_SHT_LSB +: SHT_W];
      end
      if (wr_chen) begin
        chen_d = reg_wdata[NUM_CH-1:0];
      end
      if (start_req) begin
        chan_d = ch_idx;
      end
      if (hold_end) begin
        samp_d = adc_sample;
      end
      if (seq_done) begin
        res_d  = samp_q;
        rch_d  = chan_q;
        drdy_d = 1'b1;
      end else if (rd_data) begin
        drdy_d = 1'b0;
      end
      if (seq_done && drdy_q && !rd_data) begin
        ovr_d = 1'b1;
      end else if (rd_stat) begin
        ovr_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      ten_q  <= 1'b0;
      tsel_q <= '0;
      pre_q  <= '0;
      stup_q <= '0;
      sht_q  <= '0;
      chen_q <= '0;
      drdy_q <= 1'b0;
      ovr_q  <= 1'b0;
      res_q  <= '0;
      rch_q  <= '0;
      chan_q <= '0;
      samp_q <= '0;
    end else begin
      ten_q  <= ten_d;
      tsel_q <= tsel_d;
      pre_q  <= pre_d;
      stup_q <= stup_d;
      sht_q  <= sht_d;
      chen_q <= chen_d;
      drdy_q <= drdy_d;
      ovr_q  <= ovr_d;
      res_q  <= res_d;
      rch_q  <= rch_d;
      chan_q <= chan_d;
      samp_q <= samp_d;
    end
  end

  // read mux
  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      RA_MODE: begin
        reg_rdata[MODE_TEN_BIT]                 = ten_q;
        reg_rdata[MODE_TSEL_LSB +: TSEL_W]      = tsel_q;
        reg_rdata[MODE_PRE_LSB +: PRE_W]        = pre_q;
        reg_rdata[MODE_STUP_LSB +: STUP_W]      = stup_q;
        reg_rdata[MODE_SHT_LSB +: SHT_W]        = sht_q;
      end
      RA_CHEN: reg_rdata[NUM_CH-1:0] = chen_q;
      RA_STAT: begin
        reg_rdata[STAT_RDY_BIT]  = drdy_q;
        reg_rdata[STAT_OVR_BIT]  = ovr_q;
        reg_rdata[STAT_BUSY_BIT] = seq_busy;
      end
      RA_DATA: begin
        reg_rdata[DATA_W-1:0]             = res_q;
        reg_rdata[DATA_CH_LSB +: CH_W]    = rch_q;
      end
      default: reg_rdata = '0;
    endcase
  end

  assign adc_chan   = chan_q;
  assign busy       = seq_busy;
  assign data_ready = drdy_q;

endmodule

// File: rtl/adcseq_chk.sv
module adcseq_chk #(
  parameter int CH_W = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            data_ready,
  input logic            ovr,
  input logic            done,
  input logic            soft_rst,
  input logic            rd_data,
  input logic            rd_stat,
  input logic            adc_clk,
  input logic [CH_W-1:0] adc_chan
);

  // R1
  clk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !adc_clk);

  // R2
  drdy_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_ready) |-> $past(busy));

  // R5
  chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || $stable(adc_chan)));

  // R9
  drdy_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !done && !soft_rst) |=> !data_ready);

  // R9
  ovr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> ($past(data_ready) && $past(done)));

  // R9
  ovr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !done && !soft_rst) |=> !ovr);

  // R10
  srst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!busy && !data_ready && !ovr));

endmodule

bind adc_seq adcseq_chk #(
  .CH_W (CH_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_i_n),
  .busy       (seq_busy),
  .data_ready (drdy_q),
  .ovr        (ovr_q),
  .done       (seq_done),
  .soft_rst   (soft_rst),
  .rd_data    (rd_data),
  .rd_stat    (rd_stat),
  .adc_clk    (adc_clk),
  .adc_chan   (adc_chan)
);

// File: tb/adc_seq_test.sv
module adc_seq_test;

  localparam int DW = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic        reg_rd;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [3:0]  trig_in;
  logic [DW-1:0] adc_sample;
  logic        adc_clk;
  logic [2:0]  adc_chan;
  logic        busy;
  logic        data_ready;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  adc_seq uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .trig_in    (trig_in),
    .adc_sample (adc_sample),
    .adc_clk    (adc_clk),
    .adc_chan   (adc_chan),
    .busy       (busy),
    .data_ready (data_ready)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1 reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(posedge clk);
    #1 reg_rd = 1'b0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      if (!busy) break;
    end
  endtask

  function automatic int lowest(input int m);
    for (int i = 0; i < 8; i++) if (m[i]) return i;
    return 0;
  endfunction

  // one software-started conversion with exact timing checks
  task automatic run_conv(input int p, input int s, input int h, input int mask, input int a);
    int per, th, tt, bad_clk, bad_seq, expv;
    logic [31:0] d;
    per = (p + 1) * 2;
    th  = ((s + 1) * 8 + h + 1) * per;
    tt  = th + DW * per;
    bad_clk = 0; bad_seq = 0;
    wr(3'd1, (h << 24) | (s << 16) | (p << 8));
    wr(3'd2, mask);
    adc_sample = a[DW-1:0];
    wr(3'd0, 32'h2); // R6 software start
    for (int n = 0; n <= tt; n++) begin
      if (n > 0) @(negedge clk);
      else @(negedge clk);
      if (n < 2 * per && adc_clk !== ((n % per) < (p + 1))) bad_clk++;
      if (n < tt && (busy !== 1'b1 || data_ready !== 1'b0)) bad_seq++;
      if (n == th) adc_sample = ~a[DW-1:0];
    end
    chk("R1", "adc_clk waveform errors", bad_clk, 0);
    chk("R2", "busy/ready before end", bad_seq, 0);
    chk("R2", "ready/busy at end", {data_ready, busy}, 2'b10);
    rd(3'd4, d);
    expv = (lowest(mask) << 16) | (a & 10'h3FF);
    chk("R4", "result word", d, expv);
    chk("R5", "adc_chan", adc_chan, lowest(mask));
    rd(3'd3, d);
    chk("R9", "status after data read", d, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic b1, b2, b3;
    int bad, tt, idx;
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    trig_in = '0; adc_sample = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    chk("R10", "busy/adc_clk/chan at reset", {busy, adc_clk, adc_chan}, 0);
    rd(3'd3, d); chk("R10", "status at reset", d, 0);
    rd(3'd1, d); chk("R10", "mode at reset", d, 0);
    rd(3'd4, d); chk("R10", "data at reset", d, 0);

    // R1 R2 R4 R5 R6 sweep
    idx = 0;
    for (int p = 0; p < 3; p++)
      for (int s = 0; s < 2; s++)
        for (int h = 0; h < 4; h++) begin
          int mask;
          mask = (idx * 29 + 1) & 8'hFF;
          if (mask == 0) mask = 1;
          run_conv(p, s, h, mask, (idx * 71 + 5) & 10'h3FF);
          idx++;
        end

    // R7 trigger gating
    wr(3'd1, 32'h5);   // enable, select input 2, P=S=H=0
    wr(3'd2, 32'h1);
    @(negedge clk) trig_in = 4'b0010;
    repeat (5) @(negedge clk);
    chk("R7", "other input edge ignored", busy, 0);
    trig_in = '0; repeat (3) @(negedge clk);
    wr(3'd1, 32'h4);   // enable clear
    @(negedge clk) trig_in = 4'b0100;
    repeat (5) @(negedge clk);
    chk("R7", "edge ignored while disabled", busy, 0);
    trig_in = '0; repeat (3) @(negedge clk);

    // R7 latency and R8 ignoring while busy
    wr(3'd1, 32'h5);
    @(negedge clk) trig_in = 4'b0100;
    @(negedge clk) b1 = busy;
    @(negedge clk) b2 = busy;
    @(negedge clk) b3 = busy;
    chk("R7", "start on third edge", {b1, b2, b3}, 3'b001);
    tt = (8 + 1 + DW) * 2;
    bad = 0;
    for (int n = 1; n <= tt; n++) begin
      @(negedge clk);
      if (n == 5) trig_in = '0;
      if (n == 7) trig_in = 4'b0100;
      if (n == 12) begin reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h2; end
      if (n == 13) reg_wr = 1'b0;
      if (n < tt && busy !== 1'b1) bad++;
    end
    chk("R8", "busy interrupted", bad, 0);
    chk("R8", "ready/busy at unchanged end", {data_ready, busy}, 2'b10);
    repeat (6) @(negedge clk);
    chk("R8", "no queued conversion", busy, 0);
    trig_in = '0;
    rd(3'd4, d);

    // R5 empty mask
    wr(3'd1, 32'h0);
    wr(3'd2, 32'h0);
    wr(3'd0, 32'h2);
    @(negedge clk); @(negedge clk);
    chk("R5", "start with empty mask", busy, 0);

    // R9 overrun
    wr(3'd2, 32'h0C);
    adc_sample = 10'h155;
    wr(3'd0, 32'h2); wait_idle();
    wr(3'd0, 32'h2); wait_idle();
    rd(3'd3, d); chk("R9", "ready+overrun", d, 3);
    rd(3'd3, d); chk("R9", "overrun cleared by status read", d, 1);
    rd(3'd4, d); chk("R9", "data word", d, (2 << 16) | 10'h155);
    rd(3'd3, d); chk("R9", "ready cleared by data read", {d[2:0], data_ready}, 0);

    // R3 mode and mask readback
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, d); chk("R3", "mode readback", d, 32'h0F1F_FF07);
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd2, d); chk("R3", "mask readback", d, 32'hFF);
    rd(3'd0, d); chk("R3", "command reads zero", d, 0);

    // R10 software reset during a conversion, start bit ignored
    wr(3'd0, 32'h2);
    repeat (4) @(negedge clk);
    chk("R10", "running before reset", busy, 1);
    wr(3'd0, 32'h3);
    @(negedge clk);
    chk("R10", "busy/adc_clk after reset", {busy, adc_clk}, 0);
    rd(3'd1, d); chk("R10", "mode cleared", d, 0);
    rd(3'd2, d); chk("R10", "mask cleared", d, 0);
    rd(3'd3, d); chk("R10", "status cleared", d, 0);
    rd(3'd4, d); chk("R10", "data cleared", d, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule